// File: doc/BRIEF.md
# DSP-Format Serial Audio Receiver

This block takes stereo audio sent in DSP framing and turns it into parallel samples. It runs entirely on the serial bit clock. That clock has 64 bit periods per sample frame. A rising edge of the frame strobe marks slot 0 of a frame. Starting in that slot, the left word and then the right word arrive back to back, most significant bit first. Every data bit is taken on a rising bit-clock edge.

Once the last bit of the right word is in, both channels appear on the outputs together, each left-aligned in a fixed-width bus. A single-cycle valid strobe comes with them. Any slots after the right word are discarded.

The word length is selected at run time, up to the output width. Out-of-range settings fall back to 16 bits. A strobe edge that arrives in the middle of a frame restarts reception, and the unfinished frame is thrown away.

Top module: `dspAudioRx`

## Requirements
- R1: With the synchronous active-high reset applied, `leftOut`, `rightOut` and `validOut` are zero, and the remembered strobe level is cleared. After reset, no `validOut` pulse appears until a frame start has been seen.
- R2: A frame starts when `frameSync` is sampled low on one rising `bitClk` edge and high on the next. The `serData` bit taken on that second edge is slot 0, which is the left-word MSB. A high-to-low change starts nothing.
- R3: With word length L, slots 0..L-1 carry the left word and slots L..2L-1 carry the right word. Both are sent MSB first and are sampled on rising `bitClk` edges.
- R4: `validOut` is high for exactly one cycle, directly after the edge that samples slot 2L-1. `leftOut` and `rightOut` change only on that edge and hold their values at every other time.
- R5: The data in slots 2L..63 has no effect on the outputs.
- R6: Each received word sits in the upper L bits of its 32-bit output, and the lower 32-L bits are zero.
- R7: `wordLen` values 1 to 32 select L directly. The values 0 and 33 to 63 select L = 16.
- R8: A frame start before slot 63 is reached restarts reception at slot 0. The interrupted frame produces no `validOut` and its bits do not appear in any output.
- R9: If no frame start follows slot 63, the receiver goes idle. Data is then ignored and no `validOut` occurs until the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bitClk | input | 1 | Serial bit clock, 64 periods per frame; all logic uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wordLen | input | 6 | Word length selection (1..32; other values mean 16) |
| frameSync | input | 1 | Frame strobe; a low-to-high change marks slot 0 |
| serData | input | 1 | Serial audio data, MSB first |
| leftOut | output | 32 | Left sample, left-aligned, zero-filled below |
| rightOut | output | 32 | Right sample, left-aligned, zero-filled below |
| validOut | output | 1 | One-cycle strobe when a new sample pair is present |

## Verification
The embedded assertions check the following on every cycle:
- a frame start puts the slot counter at 1 on the next edge;
- the receiver drops out of sync after slot 63 unless a new frame starts;
- `validOut` never lasts more than one cycle;
- the outputs never move without it;
- the bits below the word length are always zero when `validOut` is high.

Other behaviour can only be shown by the bench scenarios, which compare received values with independently packed words. These cover:
- bit ordering and slot placement for several word lengths, including 1 and 32;
- the fallback to 16 bits for out-of-range settings;
- immunity to random trailing data and to the falling edge of a wide strobe;
- discarding of interrupted frames.

// File: rtl/dspRxPkg.sv
package dspRxPkg;

  // Per-edge strobes from the slot control to the datapath.
  typedef struct packed {
    logic shiftEn;    // current slot carries a data bit
    logic wordStart;  // current slot is the MSB of a word
    logic leftDone;   // current slot is the last left bit
    logic frameDone;  // current slot is the last right bit
  } rxStrobes_t;

endpackage

// File: rtl/dspRxCtrl.sv
module dspRxCtrl
  import dspRxPkg::*;
#(
  parameter int OUT_W   = 32,
  parameter int SLOTS   = 64,
  parameter int DEF_LEN = 16,
  localparam int LEN_W  = $clog2(OUT_W) + 1,
  localparam int PAD_W  = $clog2(OUT_W),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] wordLen,
  input  logic             frameSync,
  output rxStrobes_t       strobes,
  output logic [PAD_W-1:0] padBits
);

  localparam int CMP_W = ((SLOT_W > LEN_W) ? SLOT_W : LEN_W) + 2;

  logic              fsPrev;
  logic              synced;
  logic [SLOT_W-1:0] slotCnt;
  logic              frameStart;
  logic              active;
  logic [SLOT_W-1:0] curSlot;
  logic [LEN_W-1:0]  effLen;
  logic [CMP_W-1:0]  slotExt;
  logic [CMP_W-1:0]  lenExt;
  logic [CMP_W-1:0]  lenTwice;

  // Word length selection with fallback for illegal codes
  always_comb begin
    if (wordLen == '0 || wordLen > LEN_W'(OUT_W)) effLen = LEN_W'(DEF_LEN);
    else                                          effLen = wordLen;
  end

  assign padBits = PAD_W'(LEN_W'(OUT_W) - effLen);

  // Frame start: strobe low on the previous edge, high on this one
  assign frameStart = frameSync & ~fsPrev;
  assign active     = frameStart | synced;
  assign curSlot    = frameStart ? '0 : slotCnt;

  assign slotExt  = CMP_W'(curSlot);
  assign lenExt   = CMP_W'(effLen);
  assign lenTwice = lenExt << 1;

  always_comb begin
    strobes           = '0;
    strobes.shiftEn   = active && (slotExt < lenTwice);
    strobes.wordStart = active && (slotExt == '0 || slotExt == lenExt);
    strobes.leftDone  = active && (slotExt == lenExt - CMP_W'(1));
    strobes.frameDone = active && (slotExt == lenTwice - CMP_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsPrev  <= 1'b0;
      synced  <= 1'b0;
      slotCnt <= '0;
    end else begin
      fsPrev <= frameSync;
      if (active) begin
        slotCnt <= curSlot + SLOT_W'(1);
        synced  <= (curSlot != SLOT_W'(SLOTS - 1));
      end
    end
  end

  // R8
  frame_restart_chk: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> (slotCnt == SLOT_W'(1)));

  // R9
  idle_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (synced && !frameStart && slotCnt == SLOT_W'(SLOTS - 1)) |=> !synced);

  // R1
  stay_unsynced_chk: assert property (@(posedge clk) disable iff (rst)
    (!synced && !frameStart) |=> !synced);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.leftDone, strobes.frameDone}));

endmodule

// File: rtl/dspRxDatapath.sv
module dspRxDatapath
  import dspRxPkg::*;
#(
  parameter int OUT_W  = 32,
  localparam int PAD_W = $clog2(OUT_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             serData,
  input  rxStrobes_t       strobes,
  input  logic [PAD_W-1:0] padBits,
  output logic [OUT_W-1:0] leftOut,
  output logic [OUT_W-1:0] rightOut,
  output logic             validOut
);

  logic [OUT_W-1:0] shReg;
  logic [OUT_W-1:0] shiftNext;
  logic [OUT_W-1:0] aligned;
  logic [OUT_W-1:0] leftHold;
  logic [OUT_W-1:0] padMask;

  // A new word restarts from an empty register; otherwise shift in at the LSB
  assign shiftNext = strobes.wordStart ? {{(OUT_W-1){1'b0}}, serData}
                                       : {shReg[OUT_W-2:0], serData};
  assign aligned   = shiftNext << padBits;

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg    <= '0;
      leftHold <= '0;
      leftOut  <= '0;
      rightOut <= '0;
      validOut <= 1'b0;
    end else begin
      validOut <= 1'b0;
      if (strobes.shiftEn)  shReg    <= shiftNext;
      if (strobes.leftDone) leftHold <= aligned;
      if (strobes.frameDone) begin
        leftOut  <= leftHold;
        rightOut <= aligned;
        validOut <= 1'b1;
      end
    end
  end

  assign padMask = (OUT_W'(1) << padBits) - OUT_W'(1);

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    validOut |=> !validOut);

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !validOut |-> ($stable(leftOut) && $stable(rightOut)));

  // R6
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    validOut |-> (((leftOut & padMask) == '0) && ((rightOut & padMask) == '0)));

endmodule

// File: rtl/dspAudioRx.sv
module dspAudioRx
  import dspRxPkg::*;
#(
  parameter int OUT_W   = 32,
  parameter int SLOTS   = 64,
  parameter int DEF_LEN = 16,
  localparam int LEN_W  = $clog2(OUT_W) + 1,
  localparam int PAD_W  = $clog2(OUT_W)
) (
  input  logic             bitClk,
  input  logic             rst,
  input  logic [LEN_W-1:0] wordLen,
  input  logic             frameSync,
  input  logic             serData,
  output logic [OUT_W-1:0] leftOut,
  output logic [OUT_W-1:0] rightOut,
  output logic             validOut
);

  rxStrobes_t       strobes;
  logic [PAD_W-1:0] padBits;

  dspRxCtrl #(.OUT_W(OUT_W), .SLOTS(SLOTS), .DEF_LEN(DEF_LEN)) ctrl (
    .clk      (bitClk),
    .rst      (rst),
    .wordLen  (wordLen),
    .frameSync(frameSync),
    .strobes  (strobes),
    .padBits  (padBits)
  );

  dspRxDatapath #(.OUT_W(OUT_W)) dpath (
    .clk     (bitClk),
    .rst     (rst),
    .serData (serData),
    .strobes (strobes),
    .padBits (padBits),
    .leftOut (leftOut),
    .rightOut(rightOut),
    .validOut(validOut)
  );

endmodule

// File: tb/dspAudioRx_test.sv
module dspAudioRx_test;

  localparam int CLK_P = 10;

  logic        bitClk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  wordLen = 6'd16;
  logic        frameSync = 1'b0;
  logic        serData = 1'b0;
  logic [31:0] leftOut, rightOut;
  logic        validOut;

  int errors = 0;
  int checks = 0;

  // Pending expectation for the edge after the last drive
  bit          havePend = 0;
  bit          pendValid;
  logic [31:0] pendL, pendR;
  string       pendTag;
  logic [31:0] lastL = '0, lastR = '0;

  dspAudioRx uut (
    .bitClk(bitClk), .rst(rst), .wordLen(wordLen), .frameSync(frameSync),
    .serData(serData), .leftOut(leftOut), .rightOut(rightOut), .validOut(validOut)
  );

  always #(CLK_P/2) bitClk = ~bitClk;

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int effLenModel(input int w);
    return (w == 0 || w > 32) ? 16 : w;
  endfunction

  function automatic logic [31:0] alignWord(input logic [31:0] v, input int len);
    longint unsigned m;
    m = ((64'd1 << len) - 64'd1) & v;
    return 32'(m << (32 - len));
  endfunction

  task automatic verifyPend();
    if (!havePend) return;
    if (pendValid) begin
      chk(validOut === 1'b1, {pendTag, " valid"}, 32'(validOut), 32'd1);
      chk(leftOut === pendL, {pendTag, " left"}, leftOut, pendL);
      chk(rightOut === pendR, {pendTag, " right"}, rightOut, pendR);
      lastL = pendL;
      lastR = pendR;
    end else begin
      chk(validOut === 1'b0, {pendTag, " no-valid"}, 32'(validOut), 32'd0);
      chk(leftOut === lastL && rightOut === lastR, {pendTag, " hold"},
          leftOut ^ rightOut, lastL ^ lastR);
    end
  endtask

  task automatic tick(input bit fs, input bit d, input bit expV,
                      input logic [31:0] eL, input logic [31:0] eR, input string tag);
    @(negedge bitClk);
    verifyPend();
    frameSync = fs;
    serData   = d;
    havePend  = 1;
    pendValid = expV;
    pendL     = eL;
    pendR     = eR;
    pendTag   = tag;
  endtask

  task automatic applyReset(input logic [5:0] w);
    @(negedge bitClk);
    verifyPend();
    havePend  = 0;
    rst       = 1'b1;
    wordLen   = w;
    frameSync = 1'b0;
    serData   = 1'b0;
    repeat (3) @(negedge bitClk);
    rst = 1'b0;
    lastL = '0;
    lastR = '0;
    // R1: outputs cleared by reset
    chk(leftOut === '0 && rightOut === '0 && validOut === 1'b0, "R1 reset",
        leftOut | rightOut | 32'(validOut), 32'd0);
  endtask

  // mode 0: one-slot strobe pulse; mode 1: strobe high for slots 0..31
  task automatic sendFrame(input int w, input logic [31:0] lv, input logic [31:0] rv,
                           input bit mode, input int stopAt, input string tag);
    int L;
    L = effLenModel(w);
    for (int s = 0; s < stopAt; s++) begin
      bit fs, d, ev;
      string t;
      fs = mode ? (s < 32) : (s == 0);
      if (s < L)          d = lv[L-1-s];
      else if (s < 2*L)   d = rv[2*L-1-s];
      else                d = 1'($urandom);
      ev = (s == 2*L - 1);
      t  = (s >= 2*L) ? "R5" : tag;
      tick(fs, d, ev, alignWord(lv, L), alignWord(rv, L), t);
    end
  endtask

  task automatic sendIdle(input int n, input bit fs, input string tag);
    for (int i = 0; i < n; i++)
      tick(fs, 1'($urandom), 1'b0, '0, '0, tag);
  endtask

  task automatic randomFrames(input int w, input int n);
    for (int i = 0; i < n; i++)
      sendFrame(w, $urandom, $urandom, 1'($urandom), 64, "R7");
  endtask

  initial begin
    void'($urandom(32'd20240517));

    // R1: reset state, then data with strobe held low yields nothing
    applyReset(6'd16);
    sendIdle(70, 1'b0, "R1");

    // R2: directed frames, pulse and wide strobe
    sendFrame(16, 32'h0000_8001, 32'h0000_7FFE, 1'b0, 64, "R2");
    sendFrame(16, 32'h0000_A5C3, 32'h0000_3C5A, 1'b1, 64, "R2");
    // R3: ordering patterns
    sendFrame(16, 32'h0000_FFFF, 32'h0000_0000, 1'b0, 64, "R3");
    sendFrame(16, 32'h0000_0001, 32'h0000_8000, 1'b1, 64, "R3");
    for (int i = 0; i < 6; i++)
      sendFrame(16, $urandom, $urandom, 1'($urandom), 64, "R3");

    // R8: aborted in the left word, then in the right word
    sendFrame(16, 32'h0000_1234, 32'h0000_5678, 1'b0, 10, "R8");
    sendFrame(16, 32'h0000_9ABC, 32'h0000_DEF0, 1'b0, 20, "R8");
    sendFrame(16, 32'h0000_4321, 32'h0000_8765, 1'b0, 64, "R8");

    // R9: no new frame start: receiver idles with strobe low, then high
    sendIdle(80, 1'b0, "R9");
    sendIdle(10, 1'b1, "R9");
    sendIdle(2, 1'b0, "R9");
    sendFrame(16, 32'h0000_0F0F, 32'h0000_F0F0, 1'b0, 64, "R9");

    // R7 / R6: other word lengths
    applyReset(6'd24);
    sendFrame(24, 32'h00AB_CDEF, 32'h0012_3456, 1'b0, 64, "R6");
    randomFrames(24, 6);
    applyReset(6'd32);
    sendFrame(32, 32'h8000_0001, 32'hDEAD_BEEF, 1'b0, 64, "R7");
    randomFrames(32, 6);
    applyReset(6'd1);
    sendFrame(1, 32'h1, 32'h0, 1'b0, 64, "R6");
    sendFrame(1, 32'h0, 32'h1, 1'b1, 64, "R6");
    randomFrames(1, 4);
    applyReset(6'd7);
    randomFrames(7, 6);
    applyReset(6'd0);
    sendFrame(0, 32'h0000_C001, 32'h0000_1003, 1'b0, 64, "R7");
    randomFrames(0, 4);
    applyReset(6'd40);
    randomFrames(40, 4);
    applyReset(6'd16);
    randomFrames(16, 20);

    sendIdle(2, 1'b0, "R9");
    @(negedge bitClk);
    verifyPend();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule